// File: doc/BRIEF.md
# DDR Region Access Guard

This block sits in front of a multi-port memory controller and decides, for each incoming read or write request, whether the request may go ahead. Every slave port has its own table of range entries. Each entry describes a window of memory in 16 KB blocks, with an inclusive last block. It also holds a two-bit permission code and a pair of master-ID filters, one for reads and one for writes.

A request arrives with its port, byte address, master ID and direction. The block searches that port's table. The lowest-numbered entry whose window contains the address decides the result. One clock later the block returns allow or deny, a hit flag and the index of the deciding entry. A simple write-only configuration interface programs one field of one entry per cycle. The same interface sets the global protection enable.

Top module: `ddr_range_guard`

## Requirements
- R1: The request address is compared in 16 KB blocks (`req_addr >> 14`), so the low 14 address bits are ignored. An entry matches when `first <= block <= last`, with both bounds inclusive. An entry whose first and last are equal covers exactly one block.
- R2: Reset state:
  - every entry of every port has `first = last = DDR_BLOCKS` (the block just above memory), code 00, and all masks and lookups zero;
  - protection is enabled;
  - `rsp_valid` is 0.
- R3: Permission code, by bit position:
  - bit 0 grants reads and bit 1 grants writes;
  - so 00 is no access, 01 is read only, 10 is write only and 11 is full access;
  - a matched request is denied when its direction's bit is clear.
- R4: The ID filter passes when `(req_id & mask) == (zero_extended(lookup) & mask)`. Reads use the read mask and read lookup. Writes use the write mask and write lookup. A failing filter denies the request.
- R5: When several entries match, the lowest-numbered one decides. `rsp_hit` is 1 and `rsp_entry` gives its index.
- R6: With protection enabled, a request that matches no entry is denied, with `rsp_hit` = 0 and `rsp_entry` = 0.
- R7: With protection disabled, every request is allowed. `rsp_hit` and `rsp_entry` still report the match.
- R8: `rsp_valid`, `rsp_allow`, `rsp_hit` and `rsp_entry` appear on the first rising edge after a cycle with `req_valid` = 1. `rsp_valid` is 0 after a cycle without a request.
- R9: Configuration writes:
  - when `cfg_we` = 1, `cfg_field` selects what is written into entry (`cfg_port`, `cfg_entry`): 0 first block, 1 last block, 2 code (`cfg_wdata[1:0]`), 3 read mask, 4 write mask, 5 read lookup, 6 write lookup;
  - field 7 sets the protection enable from `cfg_wdata[0]`;
  - only the selected field changes, so writing the last block leaves the code intact.
- R10: Each port has its own table. A write to one port never changes another port's results, and a request is checked only against its own port's table.
- R11: A request in the same cycle as a configuration write is checked against the table as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | PW (2) | Port whose table is written |
| cfg_entry | input | EW (4) | Entry index written |
| cfg_field | input | 3 | Field selector (see R9) |
| cfg_wdata | input | 18 | Write data, right-aligned |
| req_valid | input | 1 | Request present |
| req_port | input | PW (2) | Slave port of the request |
| req_addr | input | 32 | Byte address |
| req_id | input | 16 | Master ID |
| req_write | input | 1 | 1 for write, 0 for read |
| rsp_valid | output | 1 | Decision present |
| rsp_allow | output | 1 | 1 = allowed, 0 = denied |
| rsp_hit | output | 1 | Some entry matched |
| rsp_entry | output | EW (4) | Index of the deciding entry |

## Verification
Every decision is due exactly one rising edge after its request. The bench drives each request on a falling edge and reads the four response outputs on the next falling edge. There is one register between the request and the response, so that sample falls half a cycle after the result settles.

A configuration write lands on the edge after it is driven. The bench therefore starts the following request no earlier than the next falling edge, except in the deliberate same-cycle case, where the old table is expected. An idle cycle is checked the same way for `rsp_valid` = 0.

// File: rtl/drg_pkg.sv
package drg_pkg;

    localparam int ADDR_W    = 32;
    localparam int BLK_SHIFT = 14;
    localparam int BLK_W     = ADDR_W - BLK_SHIFT;
    localparam int ID_W      = 16;
    localparam int LKUP_W    = 8;
    localparam int CODE_W    = 2;
    localparam int CFG_W     = BLK_W;
    localparam int CODE_RD   = 0;
    localparam int CODE_WR   = 1;

    typedef enum logic [2:0] {
        FLD_FIRST  = 3'd0,
        FLD_LAST   = 3'd1,
        FLD_CODE   = 3'd2,
        FLD_RMASK  = 3'd3,
        FLD_WMASK  = 3'd4,
        FLD_RLKUP  = 3'd5,
        FLD_WLKUP  = 3'd6,
        FLD_ENABLE = 3'd7
    } cfg_field_e;

    typedef struct packed {
        logic [BLK_W-1:0]  first;
        logic [BLK_W-1:0]  last;
        logic [CODE_W-1:0] code;
        logic [ID_W-1:0]   rmask;
        logic [ID_W-1:0]   wmask;
        logic [LKUP_W-1:0] rlkup;
        logic [LKUP_W-1:0] wlkup;
    } range_ent_t;

    function automatic logic id_pass(input logic [ID_W-1:0]   id,
                                     input logic [ID_W-1:0]   mask,
                                     input logic [LKUP_W-1:0] lkup);
        logic [ID_W-1:0] wide;
        wide = {{(ID_W-LKUP_W){1'b0}}, lkup};
        return (id & mask) == (wide & mask);
    endfunction

endpackage

// File: rtl/drg_table.sv
module drg_table
    import drg_pkg::*;
#(
    parameter int N_PORTS    = 4,
    parameter int N_ENTRIES  = 16,
    parameter int DDR_BLOCKS = 16384,
    localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    localparam int EW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int NT = N_PORTS * N_ENTRIES,
    localparam int IW = (NT > 1) ? $clog2(NT) : 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [PW-1:0]    cfg_port,
    input  logic [EW-1:0]    cfg_entry,
    input  logic [2:0]       cfg_field,
    input  logic [CFG_W-1:0] cfg_wdata,
    output range_ent_t       tbl_o [NT],
    output logic             prot_en_o
);

    localparam range_ent_t RST_ENT = '{
        first: BLK_W'(DDR_BLOCKS),
        last:  BLK_W'(DDR_BLOCKS),
        default: '0
    };

    range_ent_t      tbl_d [NT];
    range_ent_t      tbl_q [NT];
    logic            en_d, en_q;
    logic [IW-1:0]   wr_idx;

    assign wr_idx = IW'(cfg_port) * IW'(N_ENTRIES) + IW'(cfg_entry);

    always_comb begin
        tbl_d = tbl_q;
        en_d  = en_q;
        if (cfg_we) begin
            case (cfg_field_e'(cfg_field))
                FLD_FIRST:  tbl_d[wr_idx].first = cfg_wdata[BLK_W-1:0];
                FLD_LAST:   tbl_d[wr_idx].last  = cfg_wdata[BLK_W-1:0];
                FLD_CODE:   tbl_d[wr_idx].code  = cfg_wdata[CODE_W-1:0];
                FLD_RMASK:  tbl_d[wr_idx].rmask = cfg_wdata[ID_W-1:0];
                FLD_WMASK:  tbl_d[wr_idx].wmask = cfg_wdata[ID_W-1:0];
                FLD_RLKUP:  tbl_d[wr_idx].rlkup = cfg_wdata[LKUP_W-1:0];
                FLD_WLKUP:  tbl_d[wr_idx].wlkup = cfg_wdata[LKUP_W-1:0];
                default:    en_d = cfg_wdata[0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NT; i++) begin
                tbl_q[i] <= RST_ENT;
            end
            en_q <= 1'b1;
        end else begin
            tbl_q <= tbl_d;
            en_q  <= en_d;
        end
    end

    assign tbl_o     = tbl_q;
    assign prot_en_o = en_q;

    // R9: updating the last block keeps the permission code of that entry
    assert_last_keeps_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_field == FLD_LAST) |=>
            (tbl_q[$past(wr_idx)].code == $past(tbl_q[wr_idx].code)));

    // R9: the enable field writes bit 0 of the data
    assert_enable_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_field == FLD_ENABLE) |=> (en_q == $past(cfg_wdata[0])));

endmodule

// File: rtl/drg_match.sv
module drg_match
    import drg_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int EW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
)(
    input  range_ent_t       ents [N_ENTRIES],
    input  logic [BLK_W-1:0] blk,
    input  logic [ID_W-1:0]  id,
    input  logic             is_wr,
    input  logic             en,
    output logic             allow,
    output logic             hit,
    output logic [EW-1:0]    idx
);

    logic [N_ENTRIES-1:0] hit_vec;
    logic                 win_hit;
    logic [EW-1:0]        win_idx;
    range_ent_t           win;
    logic                 code_ok;
    logic                 id_ok;

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
        assign hit_vec[e] = (blk >= ents[e].first) && (blk <= ents[e].last);
    end

    always_comb begin
        win_hit = 1'b0;
        win_idx = '0;
        for (int e = N_ENTRIES - 1; e >= 0; e--) begin
            if (hit_vec[e]) begin
                win_hit = 1'b1;
                win_idx = EW'(e);
            end
        end
    end

    always_comb begin
        win     = ents[win_idx];
        code_ok = is_wr ? win.code[CODE_WR] : win.code[CODE_RD];
        id_ok   = is_wr ? id_pass(id, win.wmask, win.wlkup)
                        : id_pass(id, win.rmask, win.rlkup);
        allow   = !en || (win_hit && code_ok && id_ok);
        hit     = win_hit;
        idx     = win_idx;
    end

    // R5: the chosen entry matches and no lower-numbered entry does
    always_comb begin
        if (win_hit) begin
            assert_winner_matches_R5: assert (hit_vec[win_idx]);
            assert_no_lower_match_R5: assert
                ((hit_vec & ((N_ENTRIES'(1) << win_idx) - N_ENTRIES'(1))) == '0);
        end
    end

endmodule

// File: rtl/ddr_range_guard.sv
module ddr_range_guard
    import drg_pkg::*;
#(
    parameter int N_PORTS    = 4,
    parameter int N_ENTRIES  = 16,
    parameter int DDR_BLOCKS = 16384,
    localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    localparam int EW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PW-1:0]     cfg_port,
    input  logic [EW-1:0]     cfg_entry,
    input  logic [2:0]        cfg_field,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic [PW-1:0]     req_port,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_hit,
    output logic [EW-1:0]     rsp_entry
);

    localparam int NT = N_PORTS * N_ENTRIES;
    localparam int IW = (NT > 1) ? $clog2(NT) : 1;

    typedef struct packed {
        logic          valid;
        logic          allow;
        logic          hit;
        logic [EW-1:0] idx;
    } rsp_t;

    range_ent_t       tbl [NT];
    range_ent_t       port_ents [N_ENTRIES];
    logic             prot_en;
    logic [BLK_W-1:0] req_blk;
    logic             m_allow, m_hit;
    logic [EW-1:0]    m_idx;
    rsp_t             rsp_d, rsp_q;
    logic             unused_offset_bits;

    assign req_blk            = req_addr[ADDR_W-1:BLK_SHIFT];
    assign unused_offset_bits = ^req_addr[BLK_SHIFT-1:0];

    drg_table #(
        .N_PORTS   (N_PORTS),
        .N_ENTRIES (N_ENTRIES),
        .DDR_BLOCKS(DDR_BLOCKS)
    ) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_port  (cfg_port),
        .cfg_entry (cfg_entry),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .tbl_o     (tbl),
        .prot_en_o (prot_en)
    );

    always_comb begin
        for (int e = 0; e < N_ENTRIES; e++) begin
            port_ents[e] = tbl[IW'(req_port) * IW'(N_ENTRIES) + IW'(e)];
        end
    end

    drg_match #(
        .N_ENTRIES(N_ENTRIES)
    ) i_match (
        .ents  (port_ents),
        .blk   (req_blk),
        .id    (req_id),
        .is_wr (req_write),
        .en    (prot_en),
        .allow (m_allow),
        .hit   (m_hit),
        .idx   (m_idx)
    );

    always_comb begin
        rsp_d.valid = req_valid;
        rsp_d.allow = req_valid && m_allow;
        rsp_d.hit   = req_valid && m_hit;
        rsp_d.idx   = req_valid ? m_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_allow = rsp_q.allow;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_entry = rsp_q.idx;

    // R8: one response exactly one edge after each request, none otherwise
    assert_rsp_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_rsp_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R7: with checking off every request passes
    assert_open_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prot_en) |=> rsp_allow);

    // R6: a miss under active checking is refused and reports entry 0
    assert_miss_denied_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_en) |=> (rsp_hit || !rsp_allow));
    assert_miss_entry_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_entry == '0));

endmodule

// File: tb/test_ddr_range_guard.sv
`timescale 1ns/1ps
module test_ddr_range_guard;

    localparam int NP  = 4;
    localparam int NE  = 16;
    localparam int TOP = 16384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_port = '0;
    logic [3:0]  cfg_entry = '0;
    logic [2:0]  cfg_field = '0;
    logic [17:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_port = '0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_id = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_allow, rsp_hit;
    logic [3:0]  rsp_entry;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_first [NP][NE];
    int m_last  [NP][NE];
    int m_code  [NP][NE];
    int m_rmask [NP][NE];
    int m_wmask [NP][NE];
    int m_rlk   [NP][NE];
    int m_wlk   [NP][NE];
    bit m_en;

    always #10 clk = ~clk;

    ddr_range_guard i_ddr_range_guard (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_entry(cfg_entry),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_port(req_port), .req_addr(req_addr),
        .req_id(req_id), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_hit(rsp_hit),
        .rsp_entry(rsp_entry)
    );

    function automatic void model(input int p, input int blk, input int id, input bit wr,
                                  output bit a, output bit h, output int ix);
        int mask, lk;
        bit cok;
        h = 0; ix = 0;
        for (int e = 0; e < NE; e++) begin
            if (!h && blk >= m_first[p][e] && blk <= m_last[p][e]) begin
                h = 1; ix = e;
            end
        end
        if (!m_en) a = 1;
        else if (!h) a = 0;
        else begin
            cok  = wr ? m_code[p][ix][1] : m_code[p][ix][0];
            mask = wr ? m_wmask[p][ix] : m_rmask[p][ix];
            lk   = wr ? m_wlk[p][ix] : m_rlk[p][ix];
            a = cok && ((id & mask) == (lk & mask));
        end
    endfunction

    function automatic void model_write(input int p, input int e, input int f, input int v);
        case (f)
            0: m_first[p][e] = v;
            1: m_last[p][e]  = v;
            2: m_code[p][e]  = v & 3;
            3: m_rmask[p][e] = v & 16'hFFFF;
            4: m_wmask[p][e] = v & 16'hFFFF;
            5: m_rlk[p][e]   = v & 8'hFF;
            6: m_wlk[p][e]   = v & 8'hFF;
            default: m_en    = v[0];
        endcase
    endfunction

    task automatic cfg_wr(input int p, input int e, input int f, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = 2'(p); cfg_entry = 4'(e);
        cfg_field = 3'(f); cfg_wdata = 18'(v);
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(p, e, f, v);
    endtask

    task automatic compare(input string tag, input int p, input int blk, input int id,
                           input bit wr, input bit ea, input bit eh, input int ei);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_allow !== ea || rsp_hit !== eh || int'(rsp_entry) != ei) begin
            failures++;
            $display("FAIL %s: port %0d blk %0d id %h wr %0b got v=%0b allow=%0b hit=%0b entry=%0d exp v=1 allow=%0b hit=%0b entry=%0d",
                     tag, p, blk, id, wr, rsp_valid, rsp_allow, rsp_hit, rsp_entry, ea, eh, ei);
        end
    endtask

    task automatic check_req(input string tag, input int p, input int blk, input int id, input bit wr);
        bit ea, eh;
        int ei;
        model(p, blk, id, wr, ea, eh, ei);
        @(negedge clk);
        req_valid = 1'b1; req_port = 2'(p); req_write = wr; req_id = 16'(id);
        req_addr = (32'(blk) << 14) | 32'((blk * 37 + id) & 16'h3FFF);
        @(negedge clk);
        req_valid = 1'b0;
        compare(tag, p, blk, id, wr, ea, eh, ei);
    endtask

    task automatic check_idle(input string tag);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL %s: rsp_valid got %0b exp 0", tag, rsp_valid);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int ids [5];
        ids = '{0, 16'h0050, 16'h12A5, 16'h00A5, 16'hFFFF};
        m_en = 1;
        for (int p = 0; p < NP; p++) begin
            for (int e = 0; e < NE; e++) begin
                m_first[p][e] = TOP; m_last[p][e] = TOP; m_code[p][e] = 0;
                m_rmask[p][e] = 0; m_wmask[p][e] = 0; m_rlk[p][e] = 0; m_wlk[p][e] = 0;
            end
        end

        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R2: rsp_valid in reset got %0b exp 0", rsp_valid);
        end
        rst_n = 1'b1;
        check_idle("R2 after reset");
        // R2: reset entries sit at the block above memory with no access
        check_req("R2 reset entry at top block", 3, TOP, 0, 1'b0);
        check_req("R2 R6 reset miss", 0, 0, 0, 1'b1);
        check_idle("R8 idle after request");

        // Port 0 table
        cfg_wr(0, 3, 0, 10); cfg_wr(0, 3, 1, 19); cfg_wr(0, 3, 2, 3);
        cfg_wr(0, 5, 0, 20); cfg_wr(0, 5, 1, 20); cfg_wr(0, 5, 2, 1);
        cfg_wr(0, 7, 0, 30); cfg_wr(0, 7, 1, 39); cfg_wr(0, 7, 2, 2);
        cfg_wr(0, 1, 0, 12); cfg_wr(0, 1, 1, 13); cfg_wr(0, 1, 2, 0);
        cfg_wr(0, 9, 0, 40); cfg_wr(0, 9, 1, 49); cfg_wr(0, 9, 2, 3);
        cfg_wr(0, 9, 3, 16'h00F0); cfg_wr(0, 9, 5, 8'h50);
        cfg_wr(0, 9, 4, 16'hFFFF); cfg_wr(0, 9, 6, 8'hA5);
        // Port 1 and port 2 tables
        cfg_wr(1, 0, 0, 10); cfg_wr(1, 0, 1, 19); cfg_wr(1, 0, 2, 1);
        cfg_wr(2, 15, 0, 0); cfg_wr(2, 15, 1, 5); cfg_wr(2, 15, 2, 3);
        cfg_wr(2, 15, 3, 16'h0F00); cfg_wr(2, 15, 5, 8'h00);

        // R1 R3 R4 R5 R6 R10: sweep every port over blocks, directions and IDs
        for (int p = 0; p < NP; p++) begin
            for (int b = 0; b <= 53; b++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int k = 0; k < 5; k++) begin
                        check_req("R1 R3 R4 R5 R6 R10 sweep", p, (b == 53) ? TOP : b, ids[k], w[0]);
                    end
                end
            end
        end

        // R9: moving the last block keeps the code
        cfg_wr(0, 3, 1, 11);
        check_req("R9 last write keeps code", 0, 11, 0, 1'b1);
        check_req("R9 R6 shrunk range", 0, 14, 0, 1'b0);

        // R11: write and request in the same cycle use the old table
        begin
            bit ea, eh;
            int ei;
            model(1, 10, 0, 1'b0, ea, eh, ei);
            @(negedge clk);
            cfg_we = 1'b1; cfg_port = 2'd1; cfg_entry = 4'd0; cfg_field = 3'd2; cfg_wdata = '0;
            req_valid = 1'b1; req_port = 2'd1; req_write = 1'b0; req_id = '0;
            req_addr = 32'(10) << 14;
            @(negedge clk);
            cfg_we = 1'b0; req_valid = 1'b0;
            model_write(1, 0, 2, 0);
            compare("R11 same-cycle write", 1, 10, 0, 1'b0, ea, eh, ei);
        end
        check_req("R11 R3 after write", 1, 10, 0, 1'b0);

        // R7: protection off
        cfg_wr(0, 0, 7, 0);
        for (int b = 0; b <= 52; b++) begin
            check_req("R7 disabled", 0, b, 16'h1234, b[0]);
        end
        cfg_wr(0, 0, 7, 1);
        check_req("R7 R6 re-enabled", 0, 0, 0, 1'b0);
        check_idle("R8 final idle");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule